// File: doc/BRIEF.md
# Pause Control Frame Generator

This block builds a complete MAC-control pause frame for full-duplex flow control and streams it one byte per accepted transfer. A single-cycle start strobe captures the station's own 48-bit address and a 16-bit pause quanta value. The block then emits a fixed 64-byte frame. The frame holds the reserved multicast destination, the captured source address, the MAC-control type, the pause opcode, the quanta, zero padding and a trailing Ethernet CRC-32 that is computed inline.

The output is a valid/ready byte stream with first and last markers. It is meant to feed a transmit path that adds the preamble and the start delimiter itself. The surrounding logic chooses when a pause frame is needed and pulses the start strobe. Strobes that arrive while a frame is still streaming are dropped.

Top module: `pause_frame_gen`

## Requirements
- R1: After reset, and before any start strobe, `valid_o` is low.
- R2: A start strobe seen while idle captures `src_addr_i` and `quanta_i`. From the next cycle, `valid_o` is high and byte 0 is presented with `first_o` high.
- R3: A frame is exactly 64 accepted bytes. `first_o` is high only on byte 0 and `last_o` is high only on byte 63.
- R4: Bytes 0 to 5 are the reserved destination 01 80 C2 00 00 01, sent in that order.
- R5: Bytes 6 to 11 are the captured source address, with bits [47:40] sent first and bits [7:0] sent last.
- R6: Bytes 12 to 15 are 88 08 00 01: the MAC-control type and then the pause opcode, each most significant byte first.
- R7: Bytes 16 and 17 are the captured quanta, with bits [15:8] sent first.
- R8: Bytes 18 to 59 are all zero.
- R9: Bytes 60 to 63 are the CRC-32 over bytes 0 to 59. The CRC uses reflected polynomial 0xEDB88320, an all-ones initial value and a final inversion, and it is sent least significant byte first.
- R10: While `valid_o` is high and `ready_i` is low, the data and markers hold steady on the next cycle, and no byte is skipped.
- R11: A start strobe during a frame has no effect, and changes on `src_addr_i` and `quanta_i` after capture do not alter the frame being sent.
- R12: After byte 63 is accepted, `valid_o` drops on the next cycle and stays low until the next start strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Single-cycle request to build a frame |
| src_addr_i | input | 48 | Local station address, first octet in bits [47:40] |
| quanta_i | input | 16 | Pause time in quanta |
| ready_i | input | 1 | Downstream accepts the current byte |
| data_o | output | 8 | Frame byte |
| valid_o | output | 1 | `data_o` holds a frame byte |
| first_o | output | 1 | Marks byte 0 |
| last_o | output | 1 | Marks the final CRC byte |

## Verification
The assertions assume that `ready_i` may drop at any time, so the stall-hold property must hold under arbitrary backpressure. They also assume that `start_i` may be pulsed at any point, including in the middle of a frame. The checker's byte counter relies on the downstream side treating a byte as taken only when `valid_o` and `ready_i` are both high. The stimulus runs every frame under three backpressure patterns: always ready, alternating, and pseudo-random. It fires a second start strobe with different field values in the middle of the frame and changes the field inputs right after capture. The stimulus sweeps corner values (all zeros and all ones) and arithmetic sequences of address and quanta. The expected bytes, including a bit-serial CRC, are computed independently in the bench.

// File: rtl/pfg_pkg.sv
package pfg_pkg;
  localparam int unsigned ADDR_W    = 48;
  localparam int unsigned QUANTA_W  = 16;
  localparam int unsigned CRC_W     = 32;
  localparam int unsigned CRC_BYTES = CRC_W / 8;
  localparam int unsigned HDR_BYTES = 2 * (ADDR_W / 8) + 6;

  localparam logic [ADDR_W-1:0] PAUSE_DA     = 48'h0180_C200_0001;
  localparam logic [15:0]       MAC_CTL_TYPE = 16'h8808;
  localparam logic [15:0]       PAUSE_OPCODE = 16'h0001;
  localparam logic [CRC_W-1:0]  CRC_POLY     = 32'hEDB8_8320;

  typedef struct packed {
    logic [ADDR_W-1:0]   sa;
    logic [QUANTA_W-1:0] quanta;
  } pause_fields_t;

  function automatic logic [CRC_W-1:0] crc32_byte(logic [CRC_W-1:0] c, logic [7:0] d);
    logic [CRC_W-1:0] r;
    r = c ^ {24'h0, d};
    for (int b = 0; b < 8; b++)
      r = r[0] ? ((r >> 1) ^ CRC_POLY) : (r >> 1);
    return r;
  endfunction
endpackage

// File: rtl/pfg_seq.sv
module pfg_seq #(
  parameter int unsigned FRAME_BYTES = 64,
  localparam int unsigned IDX_W = $clog2(FRAME_BYTES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             ready_i,
  output logic             active_o,
  output logic             load_o,
  output logic             accept_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             first_o,
  output logic             last_o
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_BYTES - 1);

  logic             active_q;
  logic [IDX_W-1:0] idx_q;

  assign load_o   = start_i & ~active_q;
  assign accept_o = active_q & ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      idx_q    <= '0;
    end else if (load_o) begin
      active_q <= 1'b1;
      idx_q    <= '0;
    end else if (accept_o) begin
      if (idx_q == LAST_IDX) begin
        active_q <= 1'b0;
        idx_q    <= '0;
      end else begin
        idx_q <= idx_q + 1'b1;
      end
    end
  end

  assign active_o = active_q;
  assign idx_o    = idx_q;
  assign first_o  = active_q & (idx_q == '0);
  assign last_o   = active_q & (idx_q == LAST_IDX);
endmodule

// File: rtl/pfg_field_mux.sv
module pfg_field_mux
  import pfg_pkg::*;
#(
  parameter int unsigned IDX_W = 6
) (
  input  pause_fields_t    fields_i,
  input  logic [IDX_W-1:0] idx_i,
  output logic [7:0]       byte_o
);
  localparam int unsigned AB    = ADDR_W / 8;
  localparam int unsigned SEL_W = $clog2(HDR_BYTES);

  logic [7:0] hdr [HDR_BYTES];

  for (genvar g = 0; g < AB; g++) begin : g_addr
    assign hdr[g]      = PAUSE_DA[8*(AB-1-g) +: 8];
    assign hdr[AB + g] = fields_i.sa[8*(AB-1-g) +: 8];
  end
  assign hdr[2*AB]     = MAC_CTL_TYPE[15:8];
  assign hdr[2*AB + 1] = MAC_CTL_TYPE[7:0];
  assign hdr[2*AB + 2] = PAUSE_OPCODE[15:8];
  assign hdr[2*AB + 3] = PAUSE_OPCODE[7:0];
  assign hdr[2*AB + 4] = fields_i.quanta[15:8];
  assign hdr[2*AB + 5] = fields_i.quanta[7:0];

  always_comb begin
    byte_o = 8'h00;
    if (idx_i < IDX_W'(HDR_BYTES)) byte_o = hdr[idx_i[SEL_W-1:0]];
  end
endmodule

// File: rtl/pfg_crc32.sv
module pfg_crc32
  import pfg_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             update_i,
  input  logic [7:0]       data_i,
  input  logic [1:0]       sel_i,
  output logic [7:0]       byte_o
);
  logic [CRC_W-1:0] crc_q;
  logic [CRC_W-1:0] fin;
  logic [7:0]       fin_b [CRC_BYTES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       crc_q <= '1;
    else if (clear_i)  crc_q <= '1;
    else if (update_i) crc_q <= crc32_byte(crc_q, data_i);
  end

  assign fin = ~crc_q;
  for (genvar g = 0; g < CRC_BYTES; g++) begin : g_fin
    assign fin_b[g] = fin[8*g +: 8];
  end
  assign byte_o = fin_b[sel_i];
endmodule

// File: rtl/pause_frame_gen.sv
module pause_frame_gen
  import pfg_pkg::*;
#(
  parameter int unsigned FRAME_BYTES = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] src_addr_i,
  input  logic [15:0]       quanta_i,
  input  logic              ready_i,
  output logic [7:0]        data_o,
  output logic              valid_o,
  output logic              first_o,
  output logic              last_o
);
  localparam int unsigned IDX_W      = $clog2(FRAME_BYTES);
  localparam int unsigned BODY_BYTES = FRAME_BYTES - CRC_BYTES;

  logic             active, load, accept;
  logic [IDX_W-1:0] idx, crc_sel;
  logic             in_body;
  logic [7:0]       body_byte, crc_byte;
  pause_fields_t    fields_q;

  pfg_seq #(.FRAME_BYTES(FRAME_BYTES)) i_seq (
    .clk_i, .rst_ni, .start_i, .ready_i,
    .active_o(active), .load_o(load), .accept_o(accept),
    .idx_o(idx), .first_o, .last_o
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   fields_q <= '0;
    else if (load) fields_q <= '{sa: src_addr_i, quanta: quanta_i};
  end

  pfg_field_mux #(.IDX_W(IDX_W)) i_mux (
    .fields_i(fields_q), .idx_i(idx), .byte_o(body_byte)
  );

  assign in_body = idx < IDX_W'(BODY_BYTES);
  assign crc_sel = idx - IDX_W'(BODY_BYTES);

  pfg_crc32 i_crc (
    .clk_i, .rst_ni,
    .clear_i(load), .update_i(accept & in_body),
    .data_i(body_byte), .sel_i(crc_sel[1:0]), .byte_o(crc_byte)
  );

  assign valid_o = active;
  assign data_o  = in_body ? body_byte : crc_byte;
endmodule

// File: rtl/pfg_checker.sv
module pfg_checker #(
  parameter int unsigned FRAME_BYTES = 64
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        start_i,
  input logic        ready_i,
  input logic [7:0]  data_o,
  input logic        valid_o,
  input logic        first_o,
  input logic        last_o
);
  localparam int unsigned CW = $clog2(FRAME_BYTES) + 1;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (valid_o && ready_i) cnt_q <= last_o ? '0 : cnt_q + 1'b1;
  end

  p_idle_holds_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o && !start_i |=> !valid_o);
  p_start_opens_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o && start_i |=> valid_o && first_o);
  p_len_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && last_o |-> cnt_q == CW'(FRAME_BYTES - 1));
  p_first_pos_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    first_o |-> cnt_q == '0 && !last_o);
  p_da_lead_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    first_o |-> data_o == 8'h01);
  p_stall_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && !ready_i |=> valid_o && $stable(data_o) && $stable(first_o) && $stable(last_o));
  p_no_restart_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && !first_o && start_i |=> !first_o);
  p_close_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && ready_i && last_o |=> !valid_o);
endmodule

bind pause_frame_gen pfg_checker #(.FRAME_BYTES(FRAME_BYTES)) i_pfg_checker (.*);

// File: tb/test_pause_frame_gen.sv
module test_pause_frame_gen;
  localparam int CLK_PERIOD = 10;
  localparam int NBYTES     = 64;
  localparam int WATCHDOG   = 150000;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [47:0] src_addr_i = '0;
  logic [15:0] quanta_i = '0;
  logic        ready_i = 1'b0;
  logic [7:0]  data_o;
  logic        valid_o, first_o, last_o;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  logic [7:0]  exp_b [NBYTES];
  logic [15:0] lfsr = 16'hACE1;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  pause_frame_gen i_pause_frame_gen (.*);

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(posedge clk_i) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected<=%0d", cycles, WATCHDOG);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  function automatic string req_of(int i);
    if (i < 6)  return "R4";
    if (i < 12) return "R5";
    if (i < 16) return "R6";
    if (i < 18) return "R7";
    if (i < 60) return "R8";
    return "R9";
  endfunction

  task automatic build(input logic [47:0] sa, input logic [15:0] q);
    logic [31:0] c;
    logic fb;
    logic [47:0] da = 48'h0180C2000001;
    for (int i = 0; i < 6; i++) begin
      exp_b[i]     = da[47-8*i -: 8];
      exp_b[6 + i] = sa[47-8*i -: 8];
    end
    exp_b[12] = 8'h88; exp_b[13] = 8'h08; exp_b[14] = 8'h00; exp_b[15] = 8'h01;
    exp_b[16] = q[15:8]; exp_b[17] = q[7:0];
    for (int i = 18; i < 60; i++) exp_b[i] = 8'h00;
    c = 32'hFFFFFFFF;
    for (int i = 0; i < 60; i++)
      for (int b = 0; b < 8; b++) begin
        fb = c[0] ^ exp_b[i][b];
        c  = c >> 1;
        if (fb) c = c ^ 32'hEDB88320;
      end
    c = ~c;
    for (int i = 0; i < 4; i++) exp_b[60 + i] = c[8*i +: 8];
  endtask

  task automatic run_frame(input logic [47:0] sa, input logic [15:0] q, input int mode, input bit inject);
    int n = 0;
    int cyc = 0;
    bit prev_stall = 0;
    logic [7:0] prev_d = '0;
    logic prev_f = 0, prev_l = 0;
    build(sa, q);
    @(negedge clk_i);
    start_i = 1'b1; src_addr_i = sa; quanta_i = q; ready_i = 1'b0;
    @(negedge clk_i);
    start_i = 1'b0;
    #1;
    check(valid_o === 1'b1 && first_o === 1'b1, "R2", {valid_o, first_o}, 2'b11);
    src_addr_i = ~sa; quanta_i = ~q;   // R11: post-capture input change
    while (n < NBYTES && cyc < 2000) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      case (mode)
        0: ready_i = 1'b1;
        1: ready_i = cyc[0];
        default: ready_i = lfsr[0];
      endcase
      start_i = inject && (cyc == 5 || cyc == 40);  // R11: strobe mid-frame
      #1;
      if (prev_stall)
        check(valid_o === 1'b1 && data_o === prev_d && first_o === prev_f && last_o === prev_l,
              "R10", {valid_o, first_o, last_o, data_o}, {1'b1, prev_f, prev_l, prev_d});
      if (valid_o && ready_i) begin
        check(data_o === exp_b[n], req_of(n), data_o, exp_b[n]);
        check(first_o === (n == 0) && last_o === (n == NBYTES - 1), "R3",
              {first_o, last_o}, {n == 0, n == NBYTES - 1});
        n++;
      end else if (!valid_o) begin
        check(1'b0, "R3", n, NBYTES);  // frame ended early
        n = NBYTES;
      end
      prev_stall = valid_o && !ready_i;
      prev_d = data_o; prev_f = first_o; prev_l = last_o;
      @(negedge clk_i);
      cyc++;
    end
    start_i = 1'b0; ready_i = 1'b1;
    #1;
    check(valid_o === 1'b0, inject ? "R11" : "R12", valid_o, 1'b0);
    @(negedge clk_i); @(negedge clk_i);
    #1;
    check(valid_o === 1'b0, "R12", valid_o, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    #1;
    check(valid_o === 1'b0, "R1", valid_o, 1'b0);
    rst_ni = 1'b1;
    ready_i = 1'b1;
    repeat (4) @(negedge clk_i);
    #1;
    check(valid_o === 1'b0, "R1", valid_o, 1'b0);
    for (int i = 0; i < 8; i++) begin
      logic [47:0] sa;
      logic [15:0] q;
      sa = (i == 0) ? 48'h0 : (i == 1) ? 48'hFFFF_FFFF_FFFF :
           {16'(i * 16'h1357), 32'(i * 32'h9E37_79B9)};
      q  = (i == 0) ? 16'h0 : (i == 1) ? 16'hFFFF : 16'(i * 16'h2B3D);
      for (int m = 0; m < 3; m++) run_frame(sa, q, m, m != 0);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule